// File: doc/BRIEF.md
# Sample Threshold Watcher

This block watches a stream of sample words leaving a sample buffer and tests each valid word against a programmable reference. It runs several independent watch channels, two by default, all fed by the same stream. Each channel has its own enable, compare direction, reference value, run-length target, interrupt enable and flag-clear strobe.

A channel counts how many qualifying samples in a row have met its condition. When the run reaches the programmed target plus one, the channel raises a sticky flag. The flag stays set until software clears it with a write-one strobe. When the channel's interrupt enable is set, the flag is passed on as an interrupt request.

Typical use is level detection on an audio or sensor stream. For example, a channel can wake the processor once a signal has stayed above a threshold for N consecutive samples.

Top module: `smp_thresh_watch`

## Requirements
- R1: A channel acts only while its enable bit is 1. While the enable is 0, valid samples never move the counter or set the flag, and the run counter is held at zero.
- R2: Samples and the reference are compared as unsigned values. Direction bit 0 tests sample < reference. Direction bit 1 tests sample >= reference.
- R3: A valid sample that meets the condition adds one to the run counter. Cycles with the valid strobe at 0 leave the counter and the flag unchanged.
- R4: A valid sample that fails the condition returns the run counter to zero, so only consecutive matches count.
- R5: The flag sets at the clock edge of the valid matching sample that makes the run reach target + 1. The target is a 4-bit field, so a target of 0 flags on a single match and a target of 15 needs 16 matches. The run counter restarts from zero after the flag sets.
- R6: The flag is sticky. A 1 on the channel's clear strobe clears it at the next edge. If a set and a clear land on the same edge, the set wins.
- R7: The interrupt output equals flag AND interrupt-enable. It is registered and changes on the same edge as the flag, or on the edge after the enable changes.
- R8: Channels are independent. One channel's configuration, run or clear never changes another channel's flag or interrupt.
- R9: Synchronous active-high reset clears every flag, interrupt and run counter.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_valid | input | 1 | Sample word valid strobe |
| smp_data | input | DW (16) | Sample word leaving the buffer |
| cfg_en | input | NCH | Per-channel compare enable |
| cfg_ie | input | NCH | Per-channel interrupt enable |
| cfg_ge | input | NCH | Per-channel direction: 0 less-than, 1 greater-or-equal |
| cfg_ref | input | NCH x DW | Per-channel reference value |
| cfg_tgt | input | NCH x CW (4) | Per-channel run target (matches needed minus one) |
| flag_clr | input | NCH | Per-channel write-one-to-clear strobe for the flag |
| flag_o | output | NCH | Per-channel sticky flag |
| irq_o | output | NCH | Per-channel interrupt request |

## Verification
The bench probes the compare boundary: a sample equal to the reference must count as greater-or-equal and not as less-than. A signed compare or an off-by-one here would flag too early or never flag. It breaks runs with a single failing sample and with an invalid cycle. A design that does not reset on a miss, or that counts idle cycles, flags early. It disables a channel mid-run and makes a set coincide with a clear. A design that keeps its count across a disable flags a sample early, and one that gives the clear priority drops an event. Target 15 and target 0 are both driven, which exposes a counter that wraps or compares against the target instead of target + 1.

// File: rtl/smw_pkg.sv
package smw_pkg;
  typedef enum logic {
    CMP_LT = 1'b0,
    CMP_GE = 1'b1
  } cmp_dir_e;
endpackage

// File: rtl/smw_compare.sv
module smw_compare #(
  parameter int DW = 16
) (
  input  logic          dir_ge,
  input  logic [DW-1:0] sample,
  input  logic [DW-1:0] refval,
  output logic          hit
);
  import smw_pkg::*;

  logic below;
  assign below = (sample < refval);

  always_comb begin
    case (cmp_dir_e'(dir_ge))
      CMP_GE:  hit = ~below;
      default: hit = below;
    endcase
  end
endmodule

// File: rtl/smw_run_counter.sv
module smw_run_counter #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          valid,
  input  logic          hit,
  input  logic [CW-1:0] tgt,
  output logic          reach
);
  logic [CW-1:0] cnt;

  assign reach = en && valid && hit && (cnt == tgt);

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      cnt <= '0;
    end else if (valid) begin
      if (!hit || reach) cnt <= '0;
      else               cnt <= cnt + 1'b1;
    end
  end

  // R4: a failing valid sample leaves the run at zero
  a_r4_miss_restarts: assert property (@(posedge clk) disable iff (rst)
    (en && valid && !hit) |=> (cnt == '0));

  // R1: a disabled channel holds no run
  a_r1_off_no_run: assert property (@(posedge clk) disable iff (rst)
    (!en) |=> (cnt == '0));

  // R3: idle cycles keep the run
  a_r3_idle_holds: assert property (@(posedge clk) disable iff (rst)
    (en && !valid && !$past(rst)) |=> $stable(cnt) || !en);
endmodule

// File: rtl/smw_channel.sv
module smw_channel #(
  parameter int DW = 16,
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          valid,
  input  logic [DW-1:0] sample,
  input  logic          en,
  input  logic          ie,
  input  logic          ge,
  input  logic [DW-1:0] refval,
  input  logic [CW-1:0] tgt,
  input  logic          clr,
  output logic          flag,
  output logic          irq
);
  logic hit;
  logic reach;
  logic flag_d;

  smw_compare #(.DW(DW)) u_cmp (
    .dir_ge (ge),
    .sample (sample),
    .refval (refval),
    .hit    (hit)
  );

  smw_run_counter #(.CW(CW)) u_run (
    .clk   (clk),
    .rst   (rst),
    .en    (en),
    .valid (valid),
    .hit   (hit),
    .tgt   (tgt),
    .reach (reach)
  );

  // set has priority over the clear strobe
  always_comb begin
    if (reach)    flag_d = 1'b1;
    else if (clr) flag_d = 1'b0;
    else          flag_d = flag;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flag <= 1'b0;
      irq  <= 1'b0;
    end else begin
      flag <= flag_d;
      irq  <= flag_d & ie;
    end
  end

  // R7: no request without a flag
  a_r7_irq_needs_flag: assert property (@(posedge clk) disable iff (rst)
    irq |-> flag);

  // R6: the flag only drops after a clear strobe
  a_r6_sticky: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $fell(flag)) |-> $past(clr));

  // R1: the flag only rises on an enabled valid sample
  a_r1_set_needs_en: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $rose(flag)) |-> $past(en && valid));
endmodule

// File: rtl/smp_thresh_watch.sv
module smp_thresh_watch #(
  parameter int NCH = 2,
  parameter int DW  = 16,
  parameter int CW  = 4
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   smp_valid,
  input  logic [DW-1:0]          smp_data,
  input  logic [NCH-1:0]         cfg_en,
  input  logic [NCH-1:0]         cfg_ie,
  input  logic [NCH-1:0]         cfg_ge,
  input  logic [NCH-1:0][DW-1:0] cfg_ref,
  input  logic [NCH-1:0][CW-1:0] cfg_tgt,
  input  logic [NCH-1:0]         flag_clr,
  output logic [NCH-1:0]         flag_o,
  output logic [NCH-1:0]         irq_o
);
  for (genvar c = 0; c < NCH; c++) begin : g_ch
    smw_channel #(.DW(DW), .CW(CW)) u_ch (
      .clk    (clk),
      .rst    (rst),
      .valid  (smp_valid),
      .sample (smp_data),
      .en     (cfg_en[c]),
      .ie     (cfg_ie[c]),
      .ge     (cfg_ge[c]),
      .refval (cfg_ref[c]),
      .tgt    (cfg_tgt[c]),
      .clr    (flag_clr[c]),
      .flag   (flag_o[c]),
      .irq    (irq_o[c])
    );
  end

  // R9: reset leaves everything quiet
  a_r9_reset_quiet: assert property (@(posedge clk)
    $past(rst) |-> (flag_o == '0 && irq_o == '0));
endmodule

// File: tb/tb_smp_thresh_watch.sv
module tb_smp_thresh_watch;
  localparam int NCH = 2;
  localparam int DW  = 16;
  localparam int CW  = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic smp_valid = 1'b0;
  logic [DW-1:0] smp_data = '0;
  logic [NCH-1:0] cfg_en = '0, cfg_ie = '0, cfg_ge = '0, flag_clr = '0;
  logic [NCH-1:0][DW-1:0] cfg_ref = '0;
  logic [NCH-1:0][CW-1:0] cfg_tgt = '0;
  logic [NCH-1:0] flag_o, irq_o;

  int n_chk = 0, n_fail = 0;

  always #2 clk = ~clk;

  smp_thresh_watch #(.NCH(NCH), .DW(DW), .CW(CW)) dut (
    .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_data(smp_data),
    .cfg_en(cfg_en), .cfg_ie(cfg_ie), .cfg_ge(cfg_ge), .cfg_ref(cfg_ref),
    .cfg_tgt(cfg_tgt), .flag_clr(flag_clr), .flag_o(flag_o), .irq_o(irq_o)
  );

  // {valid, sample[15:0], clr[1:0], exp_flag[1:0]}
  localparam int NV = 12;
  localparam logic [20:0] VEC [NV] = '{
    {1'b1, 16'h9000, 2'b00, 2'b00},
    {1'b1, 16'h8000, 2'b00, 2'b00},
    {1'b1, 16'h7FFF, 2'b00, 2'b00},
    {1'b1, 16'hFFFF, 2'b00, 2'b00},
    {1'b0, 16'h0000, 2'b00, 2'b00},
    {1'b1, 16'h8001, 2'b00, 2'b00},
    {1'b1, 16'h00FF, 2'b00, 2'b10},
    {1'b1, 16'h8000, 2'b00, 2'b10},
    {1'b1, 16'h8000, 2'b00, 2'b10},
    {1'b1, 16'h8000, 2'b00, 2'b11},
    {1'b1, 16'h0100, 2'b11, 2'b00},
    {1'b1, 16'h0000, 2'b00, 2'b10}
  };

  task automatic check(input string req, input logic [NCH-1:0] got, input logic [NCH-1:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b", req, got, exp);
    end
  endtask

  task automatic step(input logic v, input logic [DW-1:0] s, input logic [NCH-1:0] c);
    @(negedge clk);
    smp_valid = v; smp_data = s; flag_clr = c;
    @(posedge clk);
    #1;
    smp_valid = 1'b0; flag_clr = '0;
  endtask

  initial begin
    #400000;
    n_fail++; n_chk++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    // ch0: >= 0x8000, 3 in a row, irq on; ch1: < 0x0100, single match, irq off
    cfg_en = 2'b11; cfg_ie = 2'b01; cfg_ge = 2'b01;
    cfg_ref[0] = 16'h8000; cfg_ref[1] = 16'h0100;
    cfg_tgt[0] = 4'd2;     cfg_tgt[1] = 4'd0;
    repeat (3) @(posedge clk);
    #1;
    check("R9 reset flag", flag_o, 2'b00);
    check("R9 reset irq", irq_o, 2'b00);
    @(negedge clk); rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      step(VEC[i][20], VEC[i][19:4], VEC[i][3:2]);
      check($sformatf("R2 R3 R4 R5 R6 R8 row %0d flag", i), flag_o, VEC[i][1:0]);
      check($sformatf("R7 R8 row %0d irq", i), irq_o, VEC[i][1:0] & 2'b01);
    end

    // R7: interrupt enable gates an already set flag
    cfg_ie[1] = 1'b1;
    step(1'b0, 16'h0, 2'b00);
    check("R7 irq follows enable", irq_o, 2'b10);
    cfg_ie[1] = 1'b0;
    step(1'b0, 16'h0, 2'b00);
    check("R7 irq drops with enable", irq_o, 2'b00);
    step(1'b0, 16'h0, 2'b11);
    check("R6 clear both", flag_o, 2'b00);

    // R1: disable mid-run restarts the count and ignores samples
    step(1'b1, 16'h8000, 2'b00);
    step(1'b1, 16'h8000, 2'b00);
    cfg_en[0] = 1'b0;
    step(1'b1, 16'h9000, 2'b00);
    check("R1 disabled no flag", flag_o, 2'b00);
    cfg_en[0] = 1'b1;
    step(1'b1, 16'h8000, 2'b00);
    step(1'b1, 16'h8000, 2'b00);
    check("R1 run restarted after disable", flag_o, 2'b00);
    step(1'b1, 16'h8000, 2'b00);
    check("R1 third match after enable flags", flag_o, 2'b01);

    // R6: set and clear on the same edge, set wins
    step(1'b0, 16'h0, 2'b01);
    check("R6 clear ch0", flag_o, 2'b00);
    step(1'b1, 16'h8000, 2'b00);
    step(1'b1, 16'h8000, 2'b00);
    step(1'b1, 16'h8000, 2'b01);
    check("R6 set wins over clear", flag_o, 2'b01);
    step(1'b0, 16'h0, 2'b01);
    check("R6 clear after collision", flag_o, 2'b00);

    // R5: run restarts after the flag sets
    step(1'b1, 16'h8000, 2'b00);
    step(1'b1, 16'h8000, 2'b00);
    check("R5 two matches after restart", flag_o, 2'b00);
    step(1'b1, 16'h8000, 2'b00);
    check("R5 third match after restart", flag_o, 2'b01);
    step(1'b0, 16'h0, 2'b01);

    // R5: largest target needs 16 matches
    cfg_tgt[0] = 4'd15;
    for (int k = 0; k < 15; k++) step(1'b1, 16'hC000, 2'b00);
    check("R5 target 15 after 15 matches", flag_o, 2'b00);
    step(1'b1, 16'hC000, 2'b00);
    check("R5 target 15 after 16 matches", flag_o, 2'b01);
    check("R7 irq with target 15", irq_o, 2'b01);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule